// File: doc/BRIEF.md
# I2C Transmit/Receive Byte FIFO Pair with Threshold Flags

This block holds the two byte queues that sit between the register bus and the serial bit engine of an I2C controller. The transmit queue is written by the host and read by the bit engine. The receive queue is written by the bit engine and read by the host. The bit engine connects through valid/ready byte ports. The host side uses plain write and read strobes. A write strobe on a full transmit queue is reported, not stalled.

Each queue has a 4-bit programmable level. The block turns that level and the queue occupancy into registered empty, nearly-empty / nearly-full and full lines for an interrupt unit. It also emits a one-cycle overrun pulse when the host writes into a full transmit queue. The host can start a flush of either queue, or of both in one write. The flush runs for a fixed number of cycles, and its busy bit clears itself when the queue has been emptied.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After synchronous reset both queues are empty and both levels are 0. So tx_empty=1, tx_near_empty=1, tx_full=0, rx_empty=1, rx_near_full=1, rx_full=0, both flush busy bits are 0, tx_overrun=0 and host_rx_rvalid=0.
- R2: Each queue keeps 16 bytes in first-in first-out order. Empty means 0 entries and full means 16 entries. The flags take the occupancy that a clock edge produces at that same edge.
- R3: tx_near_empty is 1 exactly when the transmit occupancy is less than or equal to the transmit level. A level write through thr_tx_we (value 0..15 on thr_wdata) governs the flag from the second clock edge after the write.
- R4: rx_near_full is 1 exactly when the receive occupancy is greater than or equal to the receive level written through thr_rx_we, with the same timing as R3.
- R5: A host_tx_wr while the transmit queue holds 16 entries and is not flushing is dropped. tx_overrun is then high for the one cycle after that edge. At all other times tx_overrun is 0.
- R6: flush_we with flush_tx and/or flush_rx set starts a flush of the selected queues. The busy bit of each selected queue is 1 for exactly 4 cycles from the next edge and then returns to 0, at which point that queue is empty. A flush request on a queue that is already flushing is ignored.
- R7: While a queue is flushing, pushes into it are ignored. This covers host_tx_wr (with no overrun) and eng_rx_ready, which is 0. Pops return nothing: eng_tx_valid=0, and a host read gives host_rx_rvalid=0 with data 0.
- R8: A host read of an empty receive queue returns host_rx_rdata=0 with host_rx_rvalid=0 and changes no state.
- R9: A push and a pop on the same queue in the same cycle both take effect and leave the occupancy unchanged. On a full transmit queue the pop succeeds and the write is an overrun.
- R10: eng_tx_valid is 1 when the transmit queue is non-empty and not flushing, and it presents the oldest byte on eng_tx_data. eng_rx_ready is 1 when the receive queue is not full and not flushing.
- R11: A host read accepted at an edge delivers the oldest receive byte on host_rx_rdata, with host_rx_rvalid=1, for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_tx_wr | input | 1 | Host writes one byte into the transmit queue |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_rd | input | 1 | Host reads one byte from the receive queue |
| host_rx_rdata | output | 8 | Byte read, zero when nothing was popped |
| host_rx_rvalid | output | 1 | host_rx_rdata holds a popped byte |
| thr_tx_we | input | 1 | Load the transmit level from thr_wdata |
| thr_rx_we | input | 1 | Load the receive level from thr_wdata |
| thr_wdata | input | 4 | Level value 0..15 |
| flush_we | input | 1 | Flush request strobe |
| flush_tx | input | 1 | Flush the transmit queue with this strobe |
| flush_rx | input | 1 | Flush the receive queue with this strobe |
| tx_flush_busy | output | 1 | Transmit flush in progress |
| rx_flush_busy | output | 1 | Receive flush in progress |
| eng_tx_valid | output | 1 | Transmit byte available to the bit engine |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_ready | input | 1 | Bit engine takes the transmit byte |
| eng_rx_valid | input | 1 | Bit engine offers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Receive queue accepts a byte |
| tx_empty | output | 1 | Transmit queue empty |
| tx_near_empty | output | 1 | Transmit occupancy at or below its level |
| tx_full | output | 1 | Transmit queue full |
| tx_overrun | output | 1 | One-cycle pulse: host write into full transmit queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_near_full | output | 1 | Receive occupancy at or above its level |
| rx_full | output | 1 | Receive queue full |

## Verification
The collision that matters most is a host write landing on a full transmit queue in the same cycle the bit engine pops. The pop must succeed while the write counts as an overrun and leaves 15 entries. The same goes for a push and a pop on a partly filled queue, which must leave the occupancy unchanged. A second collision is a flush request arriving together with pushes, pops or a level write. The bench provokes both with a directed fill-to-full sequence and with long random runs biased toward full and empty. Every cycle it compares the flags, the overrun pulse, the busy bits and the data against a queue model kept in the bench.

// File: rtl/i2cfq_pkg.sv
`timescale 1ns/1ps
package i2cfq_pkg;
  typedef struct packed {
    logic empty;
    logic near;
    logic full;
  } qflags_t;

  localparam int unsigned TX_Q = 0;
  localparam int unsigned RX_Q = 1;
endpackage

// File: rtl/i2cfq_flush_seq.sv
`timescale 1ns/1ps
// Fixed-length flush sequencer: busy for CYCLES cycles, done on the last.
module i2cfq_flush_seq #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end else if (start) begin
      left <= CW'(CYCLES);
    end
  end

  assign busy = (left != '0);
  assign done = (left == CW'(1));
endmodule

// File: rtl/i2cfq_core.sv
`timescale 1ns/1ps
// One byte queue: storage, pointers, occupancy and its flush sequencer.
module i2cfq_core #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FLUSH_CYC = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [DATA_W-1:0]              push_data,
  input  logic                           pop,
  output logic [DATA_W-1:0]              pop_data,
  input  logic                           flush_start,
  output logic                           busy,
  output logic                           is_full,
  output logic                           is_empty,
  output logic [$clog2(DEPTH+1)-1:0]     count_nxt
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              flush_done;
  logic              push_ok, pop_ok;

  i2cfq_flush_seq #(.CYCLES(FLUSH_CYC)) u_flush (
    .clk   (clk),
    .rst   (rst),
    .start (flush_start),
    .busy  (busy),
    .done  (flush_done)
  );

  assign is_full  = (count == CW'(DEPTH));
  assign is_empty = (count == '0);
  assign push_ok  = push && !busy && !is_full;
  assign pop_ok   = pop  && !busy && !is_empty;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (flush_done) begin
      count_nxt = '0;
    end else begin
      unique case ({push_ok, pop_ok})
        2'b10:   count_nxt = count + 1'b1;
        2'b01:   count_nxt = count - 1'b1;
        default: count_nxt = count;
      endcase
    end
  end

  // Storage without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush_done) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
      count <= count_nxt;
    end
  end

  assign pop_data = mem[rd_ptr];
endmodule

// File: rtl/i2cfq_flags.sv
`timescale 1ns/1ps
// Registered status flags; HIGH_WATER picks ">= level" or "<= level".
module i2cfq_flags
  import i2cfq_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned TH_W       = 4,
  parameter bit          HIGH_WATER = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] count_nxt,
  input  logic [TH_W-1:0]            level,
  output qflags_t                    flags
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned MW = (CW > TH_W) ? CW : TH_W;

  logic [MW-1:0] cnt_ext, lvl_ext;
  logic          near_d;

  assign cnt_ext = MW'(count_nxt);
  assign lvl_ext = MW'(level);

  generate
    if (HIGH_WATER) begin : g_high
      assign near_d = (cnt_ext >= lvl_ext);
    end else begin : g_low
      assign near_d = (cnt_ext <= lvl_ext);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '{empty: 1'b1, near: 1'b1, full: 1'b0};
    end else begin
      flags.empty <= (count_nxt == '0);
      flags.near  <= near_d;
      flags.full  <= (count_nxt == CW'(DEPTH));
    end
  end
endmodule

// File: rtl/i2c_fifo_pair.sv
`timescale 1ns/1ps
module i2c_fifo_pair
  import i2cfq_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TH_W      = 4,
  parameter int unsigned FLUSH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_tx_wr,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              host_rx_rd,
  output logic [DATA_W-1:0] host_rx_rdata,
  output logic              host_rx_rvalid,
  input  logic              thr_tx_we,
  input  logic              thr_rx_we,
  input  logic [TH_W-1:0]   thr_wdata,
  input  logic              flush_we,
  input  logic              flush_tx,
  input  logic              flush_rx,
  output logic              tx_flush_busy,
  output logic              rx_flush_busy,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_ready,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              eng_rx_ready,
  output logic              tx_empty,
  output logic              tx_near_empty,
  output logic              tx_full,
  output logic              tx_overrun,
  output logic              rx_empty,
  output logic              rx_near_full,
  output logic              rx_full
);
  localparam int unsigned NQ = 2;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [NQ-1:0]     q_push, q_pop, q_flush, q_busy, q_full, q_empty, q_lvl_we;
  logic [DATA_W-1:0] q_wdata [NQ];
  logic [DATA_W-1:0] q_rdata [NQ];
  logic [CW-1:0]     q_cnt_nxt [NQ];
  logic [TH_W-1:0]   q_level [NQ];
  qflags_t           q_flags [NQ];

  // Channel wiring: transmit is host-in/engine-out, receive the reverse.
  assign q_push[TX_Q]   = host_tx_wr;
  assign q_wdata[TX_Q]  = host_tx_data;
  assign q_pop[TX_Q]    = eng_tx_ready;
  assign q_push[RX_Q]   = eng_rx_valid;
  assign q_wdata[RX_Q]  = eng_rx_data;
  assign q_pop[RX_Q]    = host_rx_rd;
  assign q_flush[TX_Q]  = flush_we && flush_tx;
  assign q_flush[RX_Q]  = flush_we && flush_rx;
  assign q_lvl_we[TX_Q] = thr_tx_we;
  assign q_lvl_we[RX_Q] = thr_rx_we;

  generate
    for (genvar ch = 0; ch < NQ; ch++) begin : g_q
      always_ff @(posedge clk) begin
        if (rst) begin
          q_level[ch] <= '0;
        end else if (q_lvl_we[ch]) begin
          q_level[ch] <= thr_wdata;
        end
      end

      i2cfq_core #(
        .DEPTH     (DEPTH),
        .DATA_W    (DATA_W),
        .FLUSH_CYC (FLUSH_CYC)
      ) u_core (
        .clk         (clk),
        .rst         (rst),
        .push        (q_push[ch]),
        .push_data   (q_wdata[ch]),
        .pop         (q_pop[ch]),
        .pop_data    (q_rdata[ch]),
        .flush_start (q_flush[ch]),
        .busy        (q_busy[ch]),
        .is_full     (q_full[ch]),
        .is_empty    (q_empty[ch]),
        .count_nxt   (q_cnt_nxt[ch])
      );

      i2cfq_flags #(
        .DEPTH      (DEPTH),
        .TH_W       (TH_W),
        .HIGH_WATER (ch == RX_Q)
      ) u_flags (
        .clk       (clk),
        .rst       (rst),
        .count_nxt (q_cnt_nxt[ch]),
        .level     (q_level[ch]),
        .flags     (q_flags[ch])
      );
    end
  endgenerate

  // Overrun pulse and host read return path.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_overrun     <= 1'b0;
      host_rx_rvalid <= 1'b0;
      host_rx_rdata  <= '0;
    end else begin
      tx_overrun     <= host_tx_wr && !q_busy[TX_Q] && q_full[TX_Q];
      host_rx_rvalid <= host_rx_rd && !q_busy[RX_Q] && !q_empty[RX_Q];
      host_rx_rdata  <= (host_rx_rd && !q_busy[RX_Q] && !q_empty[RX_Q])
                        ? q_rdata[RX_Q] : '0;
    end
  end

  assign eng_tx_valid  = !q_empty[TX_Q] && !q_busy[TX_Q];
  assign eng_tx_data   = q_rdata[TX_Q];
  assign eng_rx_ready  = !q_full[RX_Q] && !q_busy[RX_Q];
  assign tx_flush_busy = q_busy[TX_Q];
  assign rx_flush_busy = q_busy[RX_Q];
  assign tx_empty      = q_flags[TX_Q].empty;
  assign tx_near_empty = q_flags[TX_Q].near;
  assign tx_full       = q_flags[TX_Q].full;
  assign rx_empty      = q_flags[RX_Q].empty;
  assign rx_near_full  = q_flags[RX_Q].near;
  assign rx_full       = q_flags[RX_Q].full;
endmodule

// File: rtl/i2cfq_checker.sv
`timescale 1ns/1ps
module i2cfq_checker #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FLUSH_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              host_tx_wr,
  input logic              host_rx_rd,
  input logic [DATA_W-1:0] host_rx_rdata,
  input logic              host_rx_rvalid,
  input logic              tx_flush_busy,
  input logic              rx_flush_busy,
  input logic              eng_tx_valid,
  input logic              eng_rx_ready,
  input logic              tx_empty,
  input logic              tx_full,
  input logic              tx_overrun,
  input logic              rx_empty,
  input logic              rx_full
);
  logic [7:0] tx_run, rx_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_run <= '0;
      rx_run <= '0;
    end else begin
      tx_run <= tx_flush_busy ? tx_run + 1'b1 : '0;
      rx_run <= rx_flush_busy ? rx_run + 1'b1 : '0;
    end
  end

  p_ovr_cause_r5: assert property (@(posedge clk) disable iff (rst)
    tx_overrun |-> $past(host_tx_wr && tx_full && !tx_flush_busy));

  p_tx_flush_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_flush_busy) |-> (tx_run == 8'(FLUSH_CYC)) && tx_empty);

  p_rx_flush_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_flush_busy) |-> (rx_run == 8'(FLUSH_CYC)) && rx_empty);

  p_no_pop_in_flush_r7: assert property (@(posedge clk) disable iff (rst)
    tx_flush_busy |-> !eng_tx_valid);

  p_no_push_in_flush_r7: assert property (@(posedge clk) disable iff (rst)
    rx_flush_busy |-> !eng_rx_ready);

  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (host_rx_rd && rx_empty) |=> !host_rx_rvalid && (host_rx_rdata == '0));

  p_rx_ready_full_r10: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> !eng_rx_ready);

  p_tx_valid_empty_r10: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> !eng_tx_valid);
endmodule

bind i2c_fifo_pair i2cfq_checker #(
  .DATA_W    (DATA_W),
  .FLUSH_CYC (FLUSH_CYC)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .host_tx_wr     (host_tx_wr),
  .host_rx_rd     (host_rx_rd),
  .host_rx_rdata  (host_rx_rdata),
  .host_rx_rvalid (host_rx_rvalid),
  .tx_flush_busy  (tx_flush_busy),
  .rx_flush_busy  (rx_flush_busy),
  .eng_tx_valid   (eng_tx_valid),
  .eng_rx_ready   (eng_rx_ready),
  .tx_empty       (tx_empty),
  .tx_full        (tx_full),
  .tx_overrun     (tx_overrun),
  .rx_empty       (rx_empty),
  .rx_full        (rx_full)
);

// File: tb/sim_i2c_fifo_pair.sv
`timescale 1ns/1ps
module sim_i2c_fifo_pair;
  localparam int QD = 16;
  localparam int FL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_tx_wr = 0, host_rx_rd = 0, thr_tx_we = 0, thr_rx_we = 0;
  logic [7:0] host_tx_data = 0, eng_rx_data = 0;
  logic [3:0] thr_wdata = 0;
  logic       flush_we = 0, flush_tx = 0, flush_rx = 0;
  logic       eng_tx_ready = 0, eng_rx_valid = 0;
  logic [7:0] host_rx_rdata, eng_tx_data;
  logic       host_rx_rvalid, tx_flush_busy, rx_flush_busy, eng_tx_valid, eng_rx_ready;
  logic       tx_empty, tx_near_empty, tx_full, tx_overrun, rx_empty, rx_near_full, rx_full;

  always #2.5 clk = ~clk;

  i2c_fifo_pair u0 (
    .clk(clk), .rst(rst),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .host_rx_rd(host_rx_rd), .host_rx_rdata(host_rx_rdata), .host_rx_rvalid(host_rx_rvalid),
    .thr_tx_we(thr_tx_we), .thr_rx_we(thr_rx_we), .thr_wdata(thr_wdata),
    .flush_we(flush_we), .flush_tx(flush_tx), .flush_rx(flush_rx),
    .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_ready(eng_tx_ready),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
    .tx_empty(tx_empty), .tx_near_empty(tx_near_empty), .tx_full(tx_full),
    .tx_overrun(tx_overrun), .rx_empty(rx_empty), .rx_near_full(rx_near_full),
    .rx_full(rx_full)
  );

  int checks = 0;
  int errors = 0;

  // Bench reference model
  logic [7:0] mtx[$];
  logic [7:0] mrx[$];
  int  left_tx = 0, left_rx = 0;
  int  lvl_tx = 0, lvl_rx = 0, flag_lvl_tx = 0, flag_lvl_rx = 0;
  bit  exp_ovr = 0, exp_rvalid = 0;
  logic [7:0] exp_rdata = 0;

  task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit near_lo(int n, int l); return n <= l; endfunction
  function automatic bit near_hi(int n, int l); return n >= l; endfunction

  task automatic model_edge();
    int stx = mtx.size();
    int srx = mrx.size();
    flag_lvl_tx = lvl_tx;
    flag_lvl_rx = lvl_rx;
    exp_ovr = 0; exp_rvalid = 0; exp_rdata = 0;
    if (left_tx > 0) begin
      left_tx--;
      if (left_tx == 0) mtx.delete();
    end else begin
      if (host_tx_wr && stx == QD) exp_ovr = 1;
      if (eng_tx_ready && stx > 0) void'(mtx.pop_front());
      if (host_tx_wr && stx < QD) mtx.push_back(host_tx_data);
      if (flush_we && flush_tx) left_tx = FL;
    end
    if (left_rx > 0) begin
      left_rx--;
      if (left_rx == 0) mrx.delete();
    end else begin
      if (host_rx_rd && srx > 0) begin
        exp_rvalid = 1;
        exp_rdata = mrx.pop_front();
      end
      if (eng_rx_valid && srx < QD) mrx.push_back(eng_rx_data);
      if (flush_we && flush_rx) left_rx = FL;
    end
    if (thr_tx_we) lvl_tx = thr_wdata;
    if (thr_rx_we) lvl_rx = thr_wdata;
  endtask

  task automatic check_all();
    expect_eq("R2 tx_empty", tx_empty, mtx.size() == 0);
    expect_eq("R2 tx_full", tx_full, mtx.size() == QD);
    expect_eq("R3 tx_near_empty", tx_near_empty, near_lo(mtx.size(), flag_lvl_tx));
    expect_eq("R2 rx_empty", rx_empty, mrx.size() == 0);
    expect_eq("R2 rx_full", rx_full, mrx.size() == QD);
    expect_eq("R4 rx_near_full", rx_near_full, near_hi(mrx.size(), flag_lvl_rx));
    expect_eq("R5 tx_overrun", tx_overrun, exp_ovr);
    expect_eq("R6 tx_flush_busy", tx_flush_busy, left_tx > 0);
    expect_eq("R6 rx_flush_busy", rx_flush_busy, left_rx > 0);
    expect_eq("R10 eng_tx_valid", eng_tx_valid, mtx.size() > 0 && left_tx == 0);
    if (mtx.size() > 0 && left_tx == 0)
      expect_eq("R2 R10 eng_tx_data order", eng_tx_data, mtx[0]);
    expect_eq("R10 eng_rx_ready", eng_rx_ready, mrx.size() < QD && left_rx == 0);
    expect_eq("R11 host_rx_rvalid", host_rx_rvalid, exp_rvalid);
    expect_eq("R11 host_rx_rdata", host_rx_rdata, exp_rdata);
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    host_tx_wr = 0; host_rx_rd = 0; thr_tx_we = 0; thr_rx_we = 0;
    flush_we = 0; flush_tx = 0; flush_rx = 0; eng_tx_ready = 0; eng_rx_valid = 0;
  endtask

  task automatic set_levels(int t, int r);
    idle();
    thr_wdata = 4'(t); thr_tx_we = 1; step();
    idle();
    thr_wdata = 4'(r); thr_rx_we = 1; step();
    idle(); step();
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C2A));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    expect_eq("R1 tx_empty", tx_empty, 1);
    expect_eq("R1 tx_near_empty", tx_near_empty, 1);
    expect_eq("R1 tx_full", tx_full, 0);
    expect_eq("R1 rx_empty", rx_empty, 1);
    expect_eq("R1 rx_near_full", rx_near_full, 1);
    expect_eq("R1 rx_full", rx_full, 0);
    expect_eq("R1 busy", {tx_flush_busy, rx_flush_busy, tx_overrun, host_rx_rvalid}, 0);

    // R3/R4 levels
    set_levels(2, 3);

    // R2/R5: fill transmit queue to 16, then one more write
    for (int i = 0; i < QD; i++) begin
      idle(); host_tx_wr = 1; host_tx_data = 8'(8'hA0 + i); step();
    end
    idle(); host_tx_wr = 1; host_tx_data = 8'h55; step();
    expect_eq("R5 overrun pulse", tx_overrun, 1);
    idle(); step();
    expect_eq("R5 pulse one cycle", tx_overrun, 0);

    // R9: write and pop together on a full queue
    idle(); host_tx_wr = 1; host_tx_data = 8'h66; eng_tx_ready = 1; step();
    expect_eq("R9 full write+pop overrun", tx_overrun, 1);
    expect_eq("R9 full write+pop leaves 15", tx_full, 0);
    idle(); eng_tx_ready = 1;
    repeat (12) step();
    // 3 entries left, level 2: near_empty 0
    idle(); host_tx_wr = 1; host_tx_data = 8'h77; eng_tx_ready = 1; step();
    expect_eq("R9 push+pop keeps occupancy", tx_near_empty, 0);
    idle(); eng_tx_ready = 1;
    repeat (4) step();

    // R8: read empty receive queue
    idle(); host_rx_rd = 1; step();
    expect_eq("R8 empty read rvalid", host_rx_rvalid, 0);
    expect_eq("R8 empty read data", host_rx_rdata, 0);
    idle(); step();
    expect_eq("R8 still empty", rx_empty, 1);

    // R7/R6: load receive, flush both together, poke during flush
    for (int i = 0; i < 5; i++) begin
      idle(); eng_rx_valid = 1; eng_rx_data = 8'(8'h30 + i); step();
    end
    for (int i = 0; i < 3; i++) begin
      idle(); host_tx_wr = 1; host_tx_data = 8'(8'h10 + i); step();
    end
    idle(); flush_we = 1; flush_tx = 1; flush_rx = 1; step();
    expect_eq("R6 both busy", {tx_flush_busy, rx_flush_busy}, 2'b11);
    idle(); host_rx_rd = 1; host_tx_wr = 1; eng_rx_valid = 1; step();
    expect_eq("R7 no read during flush", host_rx_rvalid, 0);
    expect_eq("R7 no tx valid during flush", eng_tx_valid, 0);
    idle(); flush_we = 1; flush_tx = 1; step();
    idle(); step();
    idle(); step();
    expect_eq("R6 flush done tx", {tx_flush_busy, tx_empty}, 2'b01);
    expect_eq("R6 flush done rx", {rx_flush_busy, rx_empty}, 2'b01);

    // R11: read one byte back
    idle(); eng_rx_valid = 1; eng_rx_data = 8'hC3; step();
    idle(); host_rx_rd = 1; step();
    expect_eq("R11 read data", host_rx_rdata, 8'hC3);

    // Random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit fill = ((cyc / 250) % 2) == 0;
      idle();
      host_tx_wr   = ($urandom % 4) < (fill ? 3 : 1);
      host_tx_data = 8'($urandom);
      eng_tx_ready = ($urandom % 4) < (fill ? 1 : 3);
      eng_rx_valid = ($urandom % 4) < (fill ? 3 : 1);
      eng_rx_data  = 8'($urandom);
      host_rx_rd   = ($urandom % 4) < (fill ? 1 : 3);
      if ($urandom % 60 == 0) begin
        flush_we = 1; flush_tx = 1'($urandom); flush_rx = 1'($urandom);
      end
      if ($urandom % 25 == 0) begin
        thr_wdata = 4'($urandom);
        thr_tx_we = 1'($urandom);
        thr_rx_we = 1'($urandom);
      end
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule